// File: doc/BRIEF.md
# Board Operating-Mode Controller

This block holds a board controller in one of two operating modes. In system mode the host may read and write every memory and register on the board, and the program sequencer stays idle. In run mode the sequencer executes the user program. Host memory and register requests are refused in run mode, and the only host action accepted is a stop request.

A local event never switches the mode directly. A halt instruction, an exception that is not masked, or a host stop request only raises a local halt request. A central synchronizer ORs these requests across all boards and returns a global halt flag. The mode follows that flag: a raised flag ends run mode and a released flag starts it. The block also registers the returned global condition flag, and a conditional branch from the sequencer is taken only in run mode and only when that flag is set. Both returned global signals pass through a configurable number of register stages before they are used.

Top module: `brdmode_ctrl`

## Requirements
- R1: After reset the block is in system mode. `seq_run_o` is 0 and `halt_req_o` is 0. The global pipeline resets to "halt raised, condition clear", so the block stays in system mode until a released halt flag has crossed the pipeline.
- R2: In system mode, `host_grant_o` equals `host_req_i`, `host_deny_o` is 0 and `seq_run_o` is 0.
- R3: In run mode, `host_deny_o` equals `host_req_i`, `host_grant_o` is 0 and `seq_run_o` is 1.
- R4: In run mode, a global halt flag of 1 (after the pipeline) moves the block to system mode on the next clock edge.
- R5: In system mode, a global halt flag of 0 (after the pipeline) moves the block to run mode on the next clock edge.
- R6: In run mode, `halt_instr_i` = 1 sets `halt_req_o` on the next clock edge.
- R7: In run mode, an exception vector whose AND with the inverted mask is nonzero sets `halt_req_o` on the next edge. Exception bits whose mask bit is 1 have no effect.
- R8: A host stop request raises `halt_req_o` in run mode. In system mode it has no effect.
- R9: Once set, `halt_req_o` stays 1 while the block is in run mode. It is 0 from the edge that enters system mode onward and is never 1 in system mode.
- R10: `mask_wr_i` loads `mask_wdata_i` into the exception mask only in system mode. A write in run mode is ignored. The mask resets to all zeros.
- R11: `branch_take_o` is `branch_req_i` AND the pipelined global condition flag in run mode, and 0 in system mode.
- R12: Each global input reaches the mode logic after exactly `GLB_STAGES` register stages. With a pipeline of depth N, a change on the global halt input changes the mode at edge N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_halt_i | input | 1 | Global halt flag returned by the synchronizer |
| glb_cond_i | input | 1 | Global condition flag returned by the synchronizer |
| halt_instr_i | input | 1 | Sequencer has reached a halt instruction |
| exc_i | input | NUM_EXC | Exception sources, one bit each |
| mask_wr_i | input | 1 | Exception mask write strobe |
| mask_wdata_i | input | NUM_EXC | Exception mask write data (1 = masked) |
| host_req_i | input | 1 | Host memory or register access request |
| host_stop_i | input | 1 | Host stop request |
| branch_req_i | input | 1 | Sequencer asks for a conditional branch |
| seq_run_o | output | 1 | Sequencer enable (1 = run mode) |
| host_grant_o | output | 1 | Host access granted |
| host_deny_o | output | 1 | Host access refused |
| halt_req_o | output | 1 | Local halt request to the synchronizer |
| branch_take_o | output | 1 | Conditional branch is taken |

## Verification
The bench builds the block with `GLB_STAGES` = 2 and `NUM_EXC` = 4. The two-stage pipeline lets the bench show that the mode is still unchanged one edge before the expected switch, which is the R12 latency boundary. Four exception lines make it possible to mix masked and unmasked bits. They also show that a mask write made in run mode leaves the old mask in force, and that a mask written in system mode takes effect in the next run.

// File: rtl/brdmode_pkg.sv
package brdmode_pkg;

    typedef enum logic {
        MODE_SYS = 1'b0,
        MODE_RUN = 1'b1
    } mode_e;

    typedef struct packed {
        mode_e mode;
        logic  halt_req;
    } fsm_state_t;

endpackage

// File: rtl/brdmode_glb_pipe.sv
module brdmode_glb_pipe #(
    parameter int          STAGES  = 1,
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_regs
            logic [STAGES-1:0][W-1:0] stage_d;
            logic [STAGES-1:0][W-1:0] stage_q;

            always_comb begin
                stage_d[0] = d_i;
                for (int i = 1; i < STAGES; i++) begin
                    stage_d[i] = stage_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) begin
                        stage_q[i] <= RST_VAL;
                    end
                end else begin
                    stage_q <= stage_d;
                end
            end

            assign q_o = stage_q[STAGES-1];

            AST_PIPE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (stage_q[0] == $past(d_i)))
                else $error("first stage did not capture input"); // R12
        end
    endgenerate

endmodule

// File: rtl/brdmode_exc_mask.sv
module brdmode_exc_mask #(
    parameter int NUM_EXC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               wr_i,
    input  logic [NUM_EXC-1:0] wdata_i,
    input  logic [NUM_EXC-1:0] exc_i,
    output logic               unmasked_o
);

    logic [NUM_EXC-1:0] mask_d;
    logic [NUM_EXC-1:0] mask_q;

    always_comb begin
        mask_d = mask_q;
        if (wr_i && !run_i) begin
            mask_d = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign unmasked_o = |(exc_i & ~mask_q);

    AST_MASK_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> $stable(mask_q))
        else $error("mask changed in run mode"); // R10

    AST_MASK_LOAD_IN_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !run_i) |=> (mask_q == $past(wdata_i)))
        else $error("mask write lost in system mode"); // R10

endmodule

// File: rtl/brdmode_fsm.sv
module brdmode_fsm
    import brdmode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic glb_halt_s_i,
    input  logic halt_instr_i,
    input  logic exc_unmasked_i,
    input  logic host_stop_i,
    output logic run_o,
    output logic halt_req_o
);

    fsm_state_t st_d;
    fsm_state_t st_q;
    logic       local_evt;

    assign local_evt = halt_instr_i | exc_unmasked_i | host_stop_i;

    always_comb begin
        st_d = st_q;
        unique case (st_q.mode)
            MODE_SYS: begin
                st_d.halt_req = 1'b0;
                if (!glb_halt_s_i) begin
                    st_d.mode = MODE_RUN;
                end
            end
            MODE_RUN: begin
                if (glb_halt_s_i) begin
                    st_d.mode     = MODE_SYS;
                    st_d.halt_req = 1'b0;
                end else begin
                    st_d.halt_req = st_q.halt_req | local_evt;
                end
            end
            default: st_d = '{mode: MODE_SYS, halt_req: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_SYS, halt_req: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o      = (st_q.mode == MODE_RUN);
    assign halt_req_o = st_q.halt_req;

    AST_RUN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && glb_halt_s_i) |=> !run_o)
        else $error("run mode survived global halt"); // R4

    AST_SYS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !glb_halt_s_i) |=> run_o)
        else $error("system mode survived halt release"); // R5

    AST_EVT_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !glb_halt_s_i && halt_instr_i) |=> halt_req_o)
        else $error("halt instruction did not raise request"); // R6

    AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && !glb_halt_s_i && halt_req_o) |=> halt_req_o)
        else $error("halt request dropped in run mode"); // R9

    AST_NO_REQ_IN_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> !halt_req_o)
        else $error("halt request seen in system mode"); // R9

endmodule

// File: rtl/brdmode_ctrl.sv
module brdmode_ctrl #(
    parameter int GLB_STAGES = 1,
    parameter int NUM_EXC    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_halt_i,
    input  logic               glb_cond_i,
    input  logic               halt_instr_i,
    input  logic [NUM_EXC-1:0] exc_i,
    input  logic               mask_wr_i,
    input  logic [NUM_EXC-1:0] mask_wdata_i,
    input  logic               host_req_i,
    input  logic               host_stop_i,
    input  logic               branch_req_i,
    output logic               seq_run_o,
    output logic               host_grant_o,
    output logic               host_deny_o,
    output logic               halt_req_o,
    output logic               branch_take_o
);

    localparam int GLB_W = 2;
    localparam logic [GLB_W-1:0] GLB_RST = 2'b10;

    logic [GLB_W-1:0] glb_s;
    logic             glb_halt_s;
    logic             glb_cond_s;
    logic             exc_hit;
    logic             run;

    brdmode_glb_pipe #(
        .STAGES (GLB_STAGES),
        .W      (GLB_W),
        .RST_VAL(GLB_RST)
    ) u_glb_pipe (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({glb_halt_i, glb_cond_i}),
        .q_o  (glb_s)
    );

    assign glb_halt_s = glb_s[1];
    assign glb_cond_s = glb_s[0];

    brdmode_exc_mask #(
        .NUM_EXC(NUM_EXC)
    ) u_exc_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .wr_i      (mask_wr_i),
        .wdata_i   (mask_wdata_i),
        .exc_i     (exc_i),
        .unmasked_o(exc_hit)
    );

    brdmode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .glb_halt_s_i  (glb_halt_s),
        .halt_instr_i  (halt_instr_i),
        .exc_unmasked_i(exc_hit),
        .host_stop_i   (host_stop_i),
        .run_o         (run),
        .halt_req_o    (halt_req_o)
    );

    always_comb begin
        seq_run_o     = run;
        host_grant_o  = host_req_i & ~run;
        host_deny_o   = host_req_i & run;
        branch_take_o = branch_req_i & run & glb_cond_s;
    end

    AST_HOST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        host_grant_o |-> !halt_req_o)
        else $error("host granted while halt pending"); // R2

    AST_BRANCH_RUN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        branch_take_o |-> (seq_run_o && !host_grant_o))
        else $error("branch taken outside run mode"); // R11

endmodule

// File: tb/brdmode_ctrl_test.sv
module brdmode_ctrl_test;

    localparam int STG = 2;
    localparam int NE  = 4;
    localparam int LAT = STG + 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          glb_halt, glb_cond, halt_instr, mask_wr, host_req, host_stop, branch_req;
    logic [NE-1:0] exc, mask_wdata;
    logic          seq_run, host_grant, host_deny, halt_req, branch_take;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        string tag;
        logic  run;
        logic  halt;
        logic  take;
        logic  hreq;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    brdmode_ctrl #(.GLB_STAGES(STG), .NUM_EXC(NE)) uut (
        .clk(clk), .rst_n(rst_n), .glb_halt_i(glb_halt), .glb_cond_i(glb_cond),
        .halt_instr_i(halt_instr), .exc_i(exc), .mask_wr_i(mask_wr),
        .mask_wdata_i(mask_wdata), .host_req_i(host_req), .host_stop_i(host_stop),
        .branch_req_i(branch_req), .seq_run_o(seq_run), .host_grant_o(host_grant),
        .host_deny_o(host_deny), .halt_req_o(halt_req), .branch_take_o(branch_take)
    );

    task automatic expect_now(string tag, logic r, logic h, logic t);
        exp_t e;
        e.tag = tag; e.run = r; e.halt = h; e.take = t; e.hreq = host_req;
        exp_q.push_back(e);
        #0.1;
    endtask

    task automatic cmp(string tag, string what, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    initial begin : monitor
        forever begin
            wait (exp_q.size() != 0);
            begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.tag, "seq_run", seq_run, e.run);
                cmp(e.tag, "halt_req", halt_req, e.halt);
                cmp(e.tag, "branch_take", branch_take, e.take);
                cmp(e.tag, "host_grant", host_grant, e.hreq & ~e.run);
                cmp(e.tag, "host_deny", host_deny, e.hreq & e.run);
            end
        end
    end

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_exc(logic [NE-1:0] v);
        @(negedge clk); exc = v;
        edges(1);
        @(negedge clk); exc = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin : watchdog
        #100000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : driver
        rst_n = 0; glb_halt = 1; glb_cond = 0; halt_instr = 0; mask_wr = 0;
        host_req = 1; host_stop = 0; branch_req = 0; exc = '0; mask_wdata = '0;
        edges(3);
        @(negedge clk); rst_n = 1;
        edges(1);
        expect_now("R1 reset sys", 0, 0, 0);
        expect_now("R2 host granted in sys", 0, 0, 0);

        // R10: mask bit1 while in system mode
        @(negedge clk); mask_wr = 1; mask_wdata = 4'b0010;
        @(negedge clk); mask_wr = 0;

        // R5/R12: release global halt
        @(negedge clk); glb_halt = 0;
        edges(LAT - 1);
        expect_now("R12 not yet run", 0, 0, 0);
        edges(1);
        expect_now("R5 entered run", 1, 0, 0);
        expect_now("R3 host denied in run", 1, 0, 0);

        // R11 branch with condition
        @(negedge clk); glb_cond = 1; branch_req = 1;
        edges(LAT);
        expect_now("R11 branch taken", 1, 0, 1);
        @(negedge clk); glb_cond = 0;
        edges(LAT);
        expect_now("R11 cond clear no take", 1, 0, 0);
        @(negedge clk); branch_req = 0;

        // R7 masked exception ignored
        pulse_exc(4'b0010);
        expect_now("R7 masked exc ignored", 1, 0, 0);

        // R10 write in run ignored, mask stays
        @(negedge clk); mask_wr = 1; mask_wdata = 4'b0000;
        @(negedge clk); mask_wr = 0;
        pulse_exc(4'b0010);
        expect_now("R10 run write ignored", 1, 0, 0);

        // R7 unmasked exception
        @(negedge clk); exc = 4'b0110;
        edges(1);
        expect_now("R7 unmasked exc", 1, 1, 0);
        @(negedge clk); exc = '0;
        edges(4);
        expect_now("R9 request held", 1, 1, 0);

        // R4 global halt -> sys, request clears
        @(negedge clk); glb_halt = 1;
        edges(LAT - 1);
        expect_now("R12 still run", 1, 1, 0);
        edges(1);
        expect_now("R4 back to sys", 0, 0, 0);
        expect_now("R9 cleared on sys", 0, 0, 0);

        // R8 stop ignored in sys, halt instr too, branch 0
        @(negedge clk); host_stop = 1; halt_instr = 1; branch_req = 1; glb_cond = 1;
        edges(LAT);
        expect_now("R8 stop ignored in sys", 0, 0, 0);
        expect_now("R11 no take in sys", 0, 0, 0);
        @(negedge clk); host_stop = 0; halt_instr = 0; branch_req = 0; glb_cond = 0;
        mask_wr = 1; mask_wdata = 4'b0000;
        @(negedge clk); mask_wr = 0;

        // R6 halt instruction
        @(negedge clk); glb_halt = 0;
        edges(LAT);
        expect_now("R5 run again", 1, 0, 0);
        @(negedge clk); halt_instr = 1;
        edges(1);
        expect_now("R6 halt instr", 1, 1, 0);
        @(negedge clk); halt_instr = 0; glb_halt = 1;
        edges(LAT);
        expect_now("R4 sys after instr", 0, 0, 0);

        // R8 host stop in run
        @(negedge clk); glb_halt = 0;
        edges(LAT);
        @(negedge clk); host_stop = 1;
        edges(1);
        expect_now("R8 stop in run", 1, 1, 0);
        @(negedge clk); host_stop = 0; glb_halt = 1;
        edges(LAT);
        expect_now("R4 sys after stop", 0, 0, 0);

        // R10 mask cleared in sys takes effect
        @(negedge clk); glb_halt = 0;
        edges(LAT);
        pulse_exc(4'b0010);
        expect_now("R10 sys write applied", 1, 1, 0);
        @(negedge clk); glb_halt = 1;
        edges(LAT);
        expect_now("R4 final sys", 0, 0, 0);

        edges(2);
        finish_run();
    end

endmodule